// File: doc/BRIEF.md
# One-Shot Load Arming Latch

This block replaces a write-only hardware arming bit for a one-shot global load. Software pulses an arm request to say that a complete set of new shadow values has been written. The block then waits for the next counter-zero event from the PWM time base and emits a load trigger. That trigger is the only source that the global load logic listens to.

Unlike a write-only arming bit, the block shows its armed state on a status output. Software can therefore read whether a load is still pending before it writes the next batch of shadow values. After an armed load fires, the machine spends at least one cycle in a dedicated loading state. In that state it drives the trigger and discards any new arm request. It stays there for as long as counter-zero remains high.

The state is two register bits: bit 0 means armed and bit 1 means loading. Both outputs are these register bits, driven directly. The block runs on the PWM clock and has a synchronous active-high reset.

Top module: `olatch_arm_latch`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is idle (`armed`=0, `load_trig`=0).
- R2: From idle, an `arm_req` high at a rising edge moves the machine to armed (`armed`=1, `load_trig`=0) on that edge. This also holds when `ctr_zero` is high in the same cycle.
- R3: From idle, a `ctr_zero` pulse without `arm_req` leaves the machine idle. No trigger is produced.
- R4: In armed, the machine stays armed for as long as `ctr_zero` is low, whatever the value of `arm_req`.
- R5: In armed, a `ctr_zero` high at a rising edge moves the machine to loading on that edge (`load_trig`=1, `armed`=0).
- R6: In loading, the machine stays in loading while `ctr_zero` is high. It returns to idle on the first edge at which `ctr_zero` is low.
- R7: An `arm_req` seen while loading is discarded. When loading ends, the machine is idle and not armed.
- R8: `armed` and `load_trig` are never high together. The encoding with both bits set leads to idle on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PWM clock |
| rst | input | 1 | Synchronous active-high reset |
| ctr_zero | input | 1 | Time-base counter-zero event |
| arm_req | input | 1 | Arm strobe from software |
| load_trig | output | 1 | Global load trigger (state bit 1) |
| armed | output | 1 | Readable pending-load status (state bit 0) |

## Verification
The arm strobe and the counter-zero event can land on the same edge. The result depends on the state. From idle the arm must win and the zero must be dropped. In loading the zero must hold the trigger while the arm is thrown away. Armed plus zero must fire without regard to the arm strobe. Directed sequences create each of these coincidences. Weighted random traffic then makes them often, and a bench model built from the transition rules judges each cycle.

// File: rtl/olatch_pkg.sv
package olatch_pkg;
  localparam int ST_W     = 2;
  localparam int ARM_BIT  = 0;
  localparam int LOAD_BIT = 1;

  typedef enum logic [ST_W-1:0] {
    ST_IDLE  = 2'b00,
    ST_ARMED = 2'b01,
    ST_LOAD  = 2'b10,
    ST_BAD   = 2'b11
  } olatch_state_e;
endpackage

// File: rtl/olatch_next.sv
module olatch_next
  import olatch_pkg::*;
(
  input  olatch_state_e cur,
  input  logic          ctr_zero,
  input  logic          arm_req,
  output olatch_state_e nxt
);
  logic a_q, l_q, a_d, l_d;

  always_comb begin
    a_q = cur[ARM_BIT];
    l_q = cur[LOAD_BIT];
    // armed bit: hold until zero, or set by arm from not-armed, never while loading
    a_d = ~l_q & ((a_q & ~ctr_zero) | (~a_q & arm_req));
    // loading bit: entered from armed on zero, held while zero stays high
    l_d = ctr_zero & (l_q ^ a_q);
    nxt = olatch_state_e'({l_d, a_d});
  end
endmodule

// File: rtl/olatch_reg.sv
module olatch_reg
  import olatch_pkg::*;
#(
  parameter olatch_state_e RESET_ST = ST_IDLE
) (
  input  logic          clk,
  input  logic          rst,
  input  olatch_state_e d,
  output olatch_state_e q
);
  always_ff @(posedge clk) begin
    if (rst) q <= RESET_ST;
    else     q <= d;
  end
endmodule

// File: rtl/olatch_arm_latch.sv
module olatch_arm_latch
  import olatch_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ctr_zero,
  input  logic arm_req,
  output logic load_trig,
  output logic armed
);
  olatch_state_e state_q;
  olatch_state_e state_d;

  olatch_next u_next (
    .cur      (state_q),
    .ctr_zero (ctr_zero),
    .arm_req  (arm_req),
    .nxt      (state_d)
  );

  olatch_reg #(.RESET_ST(ST_IDLE)) u_reg (
    .clk (clk),
    .rst (rst),
    .d   (state_d),
    .q   (state_q)
  );

  assign load_trig = state_q[LOAD_BIT];
  assign armed     = state_q[ARM_BIT];
endmodule

// File: rtl/olatch_arm_latch_chk.sv
module olatch_arm_latch_chk (
  input logic clk,
  input logic rst,
  input logic ctr_zero,
  input logic arm_req,
  input logic load_trig,
  input logic armed
);
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!armed && !load_trig));

  a_r2_arm_from_idle: assert property (@(posedge clk) disable iff (rst)
    (!armed && !load_trig && arm_req) |=> (armed && !load_trig));

  a_r3_zero_idle_ignored: assert property (@(posedge clk) disable iff (rst)
    (!armed && !load_trig && !arm_req) |=> (!armed && !load_trig));

  a_r4_armed_hold: assert property (@(posedge clk) disable iff (rst)
    (armed && !ctr_zero) |=> (armed && !load_trig));

  a_r5_fire: assert property (@(posedge clk) disable iff (rst)
    (armed && ctr_zero) |=> (load_trig && !armed));

  a_r6_load_hold: assert property (@(posedge clk) disable iff (rst)
    (load_trig && ctr_zero) |=> (load_trig && !armed));

  a_r7_load_end_idle: assert property (@(posedge clk) disable iff (rst)
    (load_trig && !ctr_zero) |=> (!load_trig && !armed));

  a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(armed && load_trig));
endmodule

bind olatch_arm_latch olatch_arm_latch_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .ctr_zero  (ctr_zero),
  .arm_req   (arm_req),
  .load_trig (load_trig),
  .armed     (armed)
);

// File: tb/test_olatch_arm_latch.sv
module test_olatch_arm_latch;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctr_zero = 1'b0;
  logic arm_req = 1'b0;
  logic load_trig, armed;
  int checks = 0;
  int errors = 0;
  logic [1:0] model = 2'b00; // {loading, armed}

  always #2 clk = ~clk;

  olatch_arm_latch i_olatch_arm_latch (
    .clk(clk), .rst(rst), .ctr_zero(ctr_zero), .arm_req(arm_req),
    .load_trig(load_trig), .armed(armed)
  );

  function automatic logic [1:0] ref_next(logic [1:0] s, logic r, logic z, logic a);
    if (r) return 2'b00;
    case (s)
      2'b00:   return a ? 2'b01 : 2'b00;
      2'b01:   return z ? 2'b10 : 2'b01;
      2'b10:   return z ? 2'b10 : 2'b00;
      default: return 2'b00;
    endcase
  endfunction

  function automatic string ref_tag(logic [1:0] s, logic r, logic z, logic a);
    if (r) return "R1";
    case (s)
      2'b00:   return a ? "R2" : "R3";
      2'b01:   return z ? "R5" : "R4";
      2'b10:   return a ? "R7" : "R6";
      default: return "R8";
    endcase
  endfunction

  string pend_tag = "R1";

  task automatic check_now();
    checks++;
    if ({load_trig, armed} !== model) begin
      errors++;
      $display("FAIL %s: {load,armed} actual %b expected %b", pend_tag,
               {load_trig, armed}, model);
    end
    checks++;
    if (armed && load_trig) begin
      errors++;
      $display("FAIL R8: both high actual 11 expected not 11");
    end
  endtask

  // sample outputs, then drive inputs for the next edge
  task automatic step(logic r, logic z, logic a);
    @(negedge clk);
    check_now();
    rst = r; ctr_zero = z; arm_req = a;
    pend_tag = ref_tag(model, r, z, a);
    model = ref_next(model, r, z, a);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5eed_0042);
    rst = 1'b1;
    pend_tag = "R1";
    model = 2'b00;
    repeat (2) @(posedge clk);
    // R1 reset state, then directed corners
    step(0, 0, 0);
    step(0, 1, 0);           // R3 zero from idle ignored
    step(0, 1, 1);           // R2 arm and zero together from idle
    step(0, 0, 1);           // R4 arm while armed
    step(0, 0, 0);           // R4
    step(0, 1, 1);           // R5 fire with arm present
    step(0, 1, 1);           // R6/R7 hold, arm discarded
    step(0, 0, 1);           // R7 end, arm discarded
    step(0, 0, 0);           // idle expected
    step(0, 0, 1);           // R2
    step(1, 1, 1);           // R1 reset while armed
    step(0, 0, 0);
    step(0, 0, 1);
    step(0, 1, 0);           // R5
    step(0, 0, 0);           // R6 drop
    step(0, 0, 0);
    // weighted random traffic
    for (int i = 0; i < 3000; i++) begin
      logic r, z, a;
      r = ($urandom_range(0, 99) < 2);
      z = ($urandom_range(0, 99) < 35);
      a = ($urandom_range(0, 99) < 40);
      step(r, z, a);
    end
    step(0, 0, 0);
    @(negedge clk);
    check_now();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule